// File: doc/BRIEF.md
# Split-Screen Soft-Scroll Video Address Generator

This block sits between the CRT controller counters and video memory. Each cycle it turns the controller's memory address and character-row line counter into a video memory word address. It also produces a horizontal pixel delay count and a left-border extension flag. A small CPU write bus loads three registers: the split scan line, the alternate start address for the lower screen part, and the fine-scroll control byte.

A split-screen state machine runs once per frame. It has three states. In `SPL_TOP` the controller address passes through unchanged. On the `line_start` pulse of the programmed split line it takes the transition *arm*: it captures the alternate start address and enters `SPL_ARMED`. On the first `row_start` pulse after that it takes the transition *switch*. That cycle's fetch uses the captured start address, an offset is stored, and the machine enters `SPL_LOWER`. In `SPL_LOWER` the offset is added to every controller address. The transition *restart*, taken on `frame_start` from any state, has priority and returns the machine to `SPL_TOP`. Vertical fine scroll, horizontal delay and border extension apply in every state, so they act on the whole screen above and below the split.

The output word address is laid out as `{ma[13:12], row[2:0], ma[9:0]}`. Here `row` is the scrolled row select, so each row value selects one of eight 2 KB blocks.

Top module: `ssplit_scroll_gen`

## Requirements
- R1: During reset and after it, all three registers read as zero and `vaddr`, `pix_delay` and `border_ext` are zero. After reset, the address passes through with no scroll, no delay and no border extension.
- R2: A write with `cpu_we` high loads a register chosen by `cpu_sel`: 0 the split line, 1 the alternate-start high part (`cpu_wdata[5:0]` into address bits 13:8), 2 the alternate-start low byte, 3 the scroll byte. The new value affects the outputs from the next cycle.
- R3: A split line of zero disables splitting. A `line_start` with `line_num` equal to 0 never arms the machine.
- R4: A `line_start` whose `line_num` equals a nonzero split line captures the alternate start address. The first `row_start` in a later cycle produces that captured address as the effective memory address. A `row_start` in the same cycle as the arming `line_start` does not switch.
- R5: After the switch, the effective address is `crtc_ma + (captured - ma_at_switch)` modulo 2^14.
- R6: `frame_start` returns the machine to the top part from the next cycle, overriding any arming or switching in the same cycle.
- R7: Writes to the alternate start address after capture do not change the current frame. They are used at the next frame's split.
- R8: The output row field equals `(crtc_ra + scroll[6:4]) mod 8`, with no carry into the address bits. This holds above and below the split.
- R9: `pix_delay` equals `scroll[3:0]`.
- R10: `border_ext` is 1 exactly when `scroll[7]` is 1 and `col` is 0.
- R11: All outputs are registered. The inputs of one cycle appear on the outputs after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_we | input | 1 | Register write strobe |
| cpu_sel | input | 2 | Register select |
| cpu_wdata | input | 8 | Register write data |
| frame_start | input | 1 | Pulse at start of frame |
| line_start | input | 1 | Pulse at start of each scan line |
| line_num | input | 8 | Scan line number, valid with `line_start` |
| row_start | input | 1 | First fetch of a character row |
| crtc_ma | input | 14 | Controller memory address |
| crtc_ra | input | 3 | Controller raster line within character row |
| col | input | 7 | Word column within the scan line |
| vaddr | output | 15 | Video memory word address |
| pix_delay | output | 4 | Horizontal delay in high-resolution pixels |
| border_ext | output | 1 | Extended left border active |

## Verification
The bench targets four corner cases:

- **Arming line also starts a row.** The bench arms on a line whose `row_start` falls in the same cycle. A design that switched too early would emit the alternate address one row ahead.
- **Write after capture.** The bench rewrites the alternate address after capture. A design that read the live register instead of the captured copy would jump mid-frame.
- **Offset wrap and row wrap.** A controller address of 0x3FFF below the split checks that the offset sum wraps inside 14 bits. Row values of 6 and 7 with nonzero vertical scroll check that the row sum wraps inside 3 bits without corrupting the upper page bits.
- **Restart priority and disabled split.** A `frame_start` coincides with an arming `line_start`, and line 0 is presented with a split value of zero. A design with the wrong priority, or one that treated 0 as a real split line, would leave the top-part address.

// File: rtl/ssplit_pkg.sv
`timescale 1ns/1ps
package ssplit_pkg;
    typedef enum logic [1:0] {
        SPL_TOP   = 2'd0,
        SPL_ARMED = 2'd1,
        SPL_LOWER = 2'd2
    } spl_state_e;

    typedef struct packed {
        logic       bord;
        logic [2:0] vfine;
        logic [3:0] hdelay;
    } scroll_t;

    localparam logic [1:0] SEL_SPLIT  = 2'd0;
    localparam logic [1:0] SEL_ALT_HI = 2'd1;
    localparam logic [1:0] SEL_ALT_LO = 2'd2;
    localparam logic [1:0] SEL_SCROLL = 2'd3;

    localparam int ROW_W = 3;
endpackage

// File: rtl/ssplit_regs.sv
`timescale 1ns/1ps
module ssplit_regs
    import ssplit_pkg::*;
#(
    parameter int MA_W = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cpu_we,
    input  logic [1:0]      cpu_sel,
    input  logic [7:0]      cpu_wdata,
    output logic [7:0]      split_line,
    output logic [MA_W-1:0] alt_base,
    output scroll_t         scroll
);
    localparam int HI_W = MA_W - 8;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            split_line <= '0;
            alt_base   <= '0;
            scroll     <= '0;
        end else if (cpu_we) begin
            unique case (cpu_sel)
                SEL_SPLIT:  split_line <= cpu_wdata;
                SEL_ALT_HI: alt_base[MA_W-1:8] <= cpu_wdata[HI_W-1:0];
                SEL_ALT_LO: alt_base[7:0] <= cpu_wdata;
                SEL_SCROLL: scroll <= scroll_t'(cpu_wdata);
                default:    split_line <= split_line;
            endcase
        end
    end
endmodule

// File: rtl/ssplit_fsm.sv
`timescale 1ns/1ps
module ssplit_fsm
    import ssplit_pkg::*;
#(
    parameter int MA_W = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_start,
    input  logic            line_start,
    input  logic [7:0]      line_num,
    input  logic            row_start,
    input  logic [MA_W-1:0] crtc_ma,
    input  logic [7:0]      split_line,
    input  logic [MA_W-1:0] alt_base,
    output spl_state_e      state,
    output logic [MA_W-1:0] ssa_cap,
    output logic [MA_W-1:0] ma_eff
);
    spl_state_e      nxt;
    logic [MA_W-1:0] delta;
    logic            hit_split;

    assign hit_split = line_start && (split_line != 8'd0) && (line_num == split_line);

    always_comb begin
        nxt = state;
        unique case (state)
            SPL_TOP:   if (hit_split) nxt = SPL_ARMED;
            SPL_ARMED: if (row_start) nxt = SPL_LOWER;
            SPL_LOWER: nxt = SPL_LOWER;
            default:   nxt = SPL_TOP;
        endcase
        if (frame_start) nxt = SPL_TOP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SPL_TOP;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ssa_cap <= '0;
            delta   <= '0;
        end else begin
            if (state == SPL_TOP && nxt == SPL_ARMED)
                ssa_cap <= alt_base;
            if (state == SPL_ARMED && nxt == SPL_LOWER)
                delta <= ssa_cap - crtc_ma;
        end
    end

    always_comb begin
        unique case (state)
            SPL_TOP:   ma_eff = crtc_ma;
            SPL_ARMED: ma_eff = row_start ? ssa_cap : crtc_ma;
            SPL_LOWER: ma_eff = crtc_ma + delta;
            default:   ma_eff = crtc_ma;
        endcase
    end
endmodule

// File: rtl/ssplit_compose.sv
`timescale 1ns/1ps
module ssplit_compose
    import ssplit_pkg::*;
#(
    parameter int MA_W  = 14,
    parameter int COL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MA_W-5:0]  ma_low,
    input  logic [1:0]       ma_page,
    input  logic [ROW_W-1:0] crtc_ra,
    input  logic [COL_W-1:0] col,
    input  scroll_t          scroll,
    output logic [MA_W:0]    vaddr,
    output logic [3:0]       pix_delay,
    output logic             border_ext
);
    logic [ROW_W-1:0] ra_eff;

    assign ra_eff = crtc_ra + scroll.vfine;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vaddr      <= '0;
            pix_delay  <= '0;
            border_ext <= 1'b0;
        end else begin
            vaddr      <= {ma_page, ra_eff, ma_low};
            pix_delay  <= scroll.hdelay;
            border_ext <= scroll.bord && (col == '0);
        end
    end
endmodule

// File: rtl/ssplit_scroll_gen.sv
`timescale 1ns/1ps
module ssplit_scroll_gen
    import ssplit_pkg::*;
#(
    parameter int MA_W  = 14,
    parameter int COL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_we,
    input  logic [1:0]       cpu_sel,
    input  logic [7:0]       cpu_wdata,
    input  logic             frame_start,
    input  logic             line_start,
    input  logic [7:0]       line_num,
    input  logic             row_start,
    input  logic [MA_W-1:0]  crtc_ma,
    input  logic [ROW_W-1:0] crtc_ra,
    input  logic [COL_W-1:0] col,
    output logic [MA_W:0]    vaddr,
    output logic [3:0]       pix_delay,
    output logic             border_ext
);
    logic [7:0]      split_line;
    logic [MA_W-1:0] alt_base;
    scroll_t         scroll;
    spl_state_e      fsm_state;
    logic [MA_W-1:0] ssa_cap;
    logic [MA_W-1:0] ma_eff;

    ssplit_regs #(.MA_W(MA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_we     (cpu_we),
        .cpu_sel    (cpu_sel),
        .cpu_wdata  (cpu_wdata),
        .split_line (split_line),
        .alt_base   (alt_base),
        .scroll     (scroll)
    );

    ssplit_fsm #(.MA_W(MA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .line_start  (line_start),
        .line_num    (line_num),
        .row_start   (row_start),
        .crtc_ma     (crtc_ma),
        .split_line  (split_line),
        .alt_base    (alt_base),
        .state       (fsm_state),
        .ssa_cap     (ssa_cap),
        .ma_eff      (ma_eff)
    );

    ssplit_compose #(.MA_W(MA_W), .COL_W(COL_W)) u_compose (
        .clk        (clk),
        .rst_n      (rst_n),
        .ma_low     (ma_eff[MA_W-5:0]),
        .ma_page    (ma_eff[MA_W-1:MA_W-2]),
        .crtc_ra    (crtc_ra),
        .col        (col),
        .scroll     (scroll),
        .vaddr      (vaddr),
        .pix_delay  (pix_delay),
        .border_ext (border_ext)
    );
endmodule

// File: rtl/ssplit_scroll_gen_chk.sv
`timescale 1ns/1ps
module ssplit_scroll_gen_chk
    import ssplit_pkg::*;
#(
    parameter int MA_W  = 14,
    parameter int COL_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             row_start,
    input logic [ROW_W-1:0] crtc_ra,
    input logic [COL_W-1:0] col,
    input logic [7:0]       split_line,
    input spl_state_e       fsm_state,
    input logic [MA_W-1:0]  ssa_cap,
    input logic [MA_W-1:0]  ma_eff,
    input scroll_t          scroll,
    input logic [MA_W:0]    vaddr,
    input logic [3:0]       pix_delay,
    input logic             border_ext
);
    logic [ROW_W-1:0] exp_ra;
    logic             exp_bord;
    assign exp_ra   = crtc_ra + scroll.vfine;
    assign exp_bord = scroll.bord && (col == '0);

    p_split_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == SPL_TOP && split_line == 8'd0) |=> fsm_state != SPL_ARMED);

    p_entry_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == SPL_ARMED && row_start) |-> ma_eff == ssa_cap);

    p_frame_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> fsm_state == SPL_TOP);

    p_cap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state != SPL_TOP && !frame_start) |=> $stable(ssa_cap));

    p_row_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> vaddr[MA_W-2:MA_W-4] == $past(exp_ra));

    p_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pix_delay == $past(scroll.hdelay));

    p_border_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exp_bord |=> border_ext);

    p_border_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !exp_bord |=> !border_ext);
endmodule

bind ssplit_scroll_gen ssplit_scroll_gen_chk #(.MA_W(MA_W), .COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .row_start   (row_start),
    .crtc_ra     (crtc_ra),
    .col         (col),
    .split_line  (split_line),
    .fsm_state   (fsm_state),
    .ssa_cap     (ssa_cap),
    .ma_eff      (ma_eff),
    .scroll      (scroll),
    .vaddr       (vaddr),
    .pix_delay   (pix_delay),
    .border_ext  (border_ext)
);

// File: tb/ssplit_scroll_gen_bench.sv
`timescale 1ns/1ps
module ssplit_scroll_gen_bench;
    localparam int MA_W  = 14;
    localparam int COL_W = 7;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cpu_we;
    logic [1:0]       cpu_sel;
    logic [7:0]       cpu_wdata;
    logic             frame_start, line_start, row_start;
    logic [7:0]       line_num;
    logic [MA_W-1:0]  crtc_ma;
    logic [2:0]       crtc_ra;
    logic [COL_W-1:0] col;
    logic [MA_W:0]    vaddr;
    logic [3:0]       pix_delay;
    logic             border_ext;

    always #2.5 clk = ~clk;

    ssplit_scroll_gen #(.MA_W(MA_W), .COL_W(COL_W)) u_ssplit_scroll_gen (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_sel(cpu_sel),
        .cpu_wdata(cpu_wdata), .frame_start(frame_start), .line_start(line_start),
        .line_num(line_num), .row_start(row_start), .crtc_ma(crtc_ma),
        .crtc_ra(crtc_ra), .col(col), .vaddr(vaddr), .pix_delay(pix_delay),
        .border_ext(border_ext)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [MA_W:0] q_va[$];
    logic [3:0]    q_dly[$];
    logic          q_bd[$];
    string         q_tag[$];

    // reference model state
    logic [7:0]      m_split = '0;
    logic [MA_W-1:0] m_alt = '0;
    logic [7:0]      m_scr = '0;
    int              m_st = 0;
    logic [MA_W-1:0] m_cap = '0;
    logic [MA_W-1:0] m_delta = '0;

    function automatic logic [MA_W:0] pack_addr(logic [MA_W-1:0] m, logic [2:0] r);
        return {m[MA_W-1:MA_W-2], r, m[MA_W-5:0]};
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic step(input logic fs, input logic ls, input logic [7:0] ln,
                        input logic rs, input logic [MA_W-1:0] ma, input logic [2:0] ra,
                        input logic [COL_W-1:0] c, input logic we, input logic [1:0] sel,
                        input logic [7:0] wd, input string tag);
        logic [MA_W-1:0] me;
        logic [2:0]      rae;
        int              ns;
        @(negedge clk);
        frame_start = fs; line_start = ls; line_num = ln; row_start = rs;
        crtc_ma = ma; crtc_ra = ra; col = c; cpu_we = we; cpu_sel = sel; cpu_wdata = wd;
        if (m_st == 1 && rs)  me = m_cap;
        else if (m_st == 2)   me = ma + m_delta;
        else                  me = ma;
        rae = ra + m_scr[6:4];
        q_va.push_back(pack_addr(me, rae));
        q_dly.push_back(m_scr[3:0]);
        q_bd.push_back(m_scr[7] && (c == '0));
        q_tag.push_back(tag);
        ns = m_st;
        if (m_st == 0 && ls && m_split != 0 && ln == m_split) ns = 1;
        else if (m_st == 1 && rs) ns = 2;
        if (fs) ns = 0;
        if (m_st == 0 && ns == 1) m_cap = m_alt;
        if (m_st == 1 && ns == 2) m_delta = m_cap - ma;
        m_st = ns;
        if (we) begin
            case (sel)
                2'd0: m_split = wd;
                2'd1: m_alt[MA_W-1:8] = wd[MA_W-9:0];
                2'd2: m_alt[7:0] = wd;
                default: m_scr = wd;
            endcase
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] wd);
        step(0, 0, 0, 0, '0, 3'd0, 7'd1, 1, sel, wd, "R2");
    endtask

    task automatic ln_(input logic fs, input logic ls, input logic [7:0] ln, input logic rs,
                       input logic [MA_W-1:0] ma, input logic [2:0] ra,
                       input logic [COL_W-1:0] c, input string tag);
        step(fs, ls, ln, rs, ma, ra, c, 0, 2'd0, 8'd0, tag);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_va.size() > 0) begin
                string t;
                t = q_tag.pop_front();
                check(t, "vaddr", int'(vaddr), int'(q_va.pop_front()));
                check(t, "pix_delay", int'(pix_delay), int'(q_dly.pop_front()));
                check(t, "border_ext", int'(border_ext), int'(q_bd.pop_front()));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R11 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        cpu_we = 0; cpu_sel = 0; cpu_wdata = 0;
        frame_start = 0; line_start = 0; line_num = 0; row_start = 0;
        crtc_ma = 14'h1234; crtc_ra = 3'd5; col = '0;
        repeat (3) @(negedge clk);
        check("R1", "reset vaddr", int'(vaddr), 0);
        check("R1", "reset pix_delay", int'(pix_delay), 0);
        check("R1", "reset border_ext", int'(border_ext), 0);
        rst_n = 1'b1;

        // R1: registers start at zero -> plain pass-through
        ln_(0, 0, 0, 0, 14'h1234, 3'd5, 7'd0, "R1");
        ln_(1, 0, 0, 0, 14'h0000, 3'd0, 7'd3, "R11");
        // R3: split value zero, line 0 never arms
        ln_(0, 1, 0, 1, 14'h0100, 3'd0, 7'd2, "R3");
        ln_(0, 0, 0, 1, 14'h0200, 3'd1, 7'd2, "R3");
        // R8 / R9: vertical wrap and horizontal delay
        wr(2'd3, 8'h35);
        ln_(0, 0, 0, 0, 14'h3C05, 3'd6, 7'd3, "R8");
        ln_(0, 0, 0, 0, 14'h0C00, 3'd7, 7'd3, "R8");
        ln_(0, 0, 0, 0, 14'h0001, 3'd2, 7'd3, "R9");
        // R10: border extension only at column 0
        wr(2'd3, 8'h8A);
        ln_(0, 0, 0, 0, 14'h0010, 3'd0, 7'd0, "R10");
        ln_(0, 0, 0, 0, 14'h0011, 3'd0, 7'd1, "R10");
        ln_(0, 0, 0, 0, 14'h0012, 3'd0, 7'h40, "R10");
        wr(2'd3, 8'h20);
        // R4 / R5: split at line 4, alternate start 0x2ABC
        wr(2'd0, 8'd4);
        wr(2'd1, 8'h2A);
        wr(2'd2, 8'hBC);
        ln_(1, 0, 0, 0, 14'h0000, 3'd0, 7'd1, "R6");
        ln_(0, 1, 3, 1, 14'h0050, 3'd3, 7'd1, "R4");
        ln_(0, 1, 4, 1, 14'h00A0, 3'd4, 7'd1, "R4");
        ln_(0, 0, 0, 0, 14'h00A1, 3'd4, 7'd1, "R4");
        // R7: rewrite the alternate start after capture
        wr(2'd1, 8'h11);
        wr(2'd2, 8'h11);
        ln_(0, 0, 0, 1, 14'h00F0, 3'd0, 7'd0, "R4");
        ln_(0, 0, 0, 0, 14'h00F1, 3'd0, 7'd1, "R5");
        ln_(0, 1, 5, 0, 14'h00F2, 3'd1, 7'd1, "R7");
        ln_(0, 0, 0, 1, 14'h0140, 3'd7, 7'd1, "R8");
        ln_(0, 1, 4, 0, 14'h3FFF, 3'd2, 7'd1, "R5");
        // R6: frame restart
        ln_(1, 0, 0, 0, 14'h0200, 3'd0, 7'd1, "R6");
        ln_(0, 0, 0, 0, 14'h0200, 3'd0, 7'd1, "R6");
        // R7: next frame uses the rewritten start 0x1111
        ln_(0, 1, 4, 0, 14'h0010, 3'd0, 7'd1, "R7");
        ln_(0, 0, 0, 1, 14'h0020, 3'd0, 7'd1, "R7");
        ln_(0, 0, 0, 0, 14'h0025, 3'd0, 7'd1, "R5");
        // R6: restart overrides an arming line in the same cycle
        ln_(1, 1, 4, 0, 14'h0030, 3'd0, 7'd1, "R6");
        ln_(0, 0, 0, 1, 14'h0031, 3'd0, 7'd1, "R6");
        ln_(0, 0, 0, 1, 14'h0032, 3'd0, 7'd1, "R6");
        // R3: disable split again
        wr(2'd0, 8'd0);
        ln_(1, 0, 0, 0, 14'h0000, 3'd0, 7'd1, "R3");
        ln_(0, 1, 0, 0, 14'h0100, 3'd0, 7'd1, "R3");
        ln_(0, 1, 4, 1, 14'h0101, 3'd0, 7'd1, "R3");
        ln_(0, 0, 0, 1, 14'h0102, 3'd0, 7'd1, "R3");
        @(negedge clk);
        cpu_we = 0; frame_start = 0; line_start = 0; row_start = 0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule